// File: doc/BRIEF.md
# Sign-Sign Adaptive Oscillator Gain Tracker

This block keeps a running estimate of the ratio between the reference frequency and the oscillator's tuning gain. A two-point frequency modulator uses that ratio to scale the high-pass modulation path, so that the frequency step the oscillator makes for a given modulation word matches the step the divider path asks for. The estimate adapts in the background for as long as the loop is locked and modulating. On every reference cycle with calibration enabled, the block takes two signs. One is the sign of the filtered phase error. The other is the sign of the change in the modulation sample since the previous cycle. If the two signs agree, the estimate moves up by a programmable power-of-two step. If they disagree, it moves down by that step. If either sign is zero, the estimate is held. Every move stops at programmable floor and ceiling values.

When calibration stops at the end of a burst, the estimate reached so far is committed to a saved register. Each new packet begins by reloading the working estimate from that saved value. The block also multiplies each incoming modulation sample by the current estimate in a registered stage and presents the product as the word for the oscillator's tuning input.

Top module: `osc_gain_tracker`

## Requirements
- R1: After reset, `gain_out` is 0x4000 (parameter `INIT_GAIN`), `mod_out` is 0, the saved estimate is 0x4000 and the previous-sample register is 0.
- R2: On a clock edge with `cal_en`=1 and `pkt_start`=0, the estimate rises by one step if `ph_err` and (`mod_in` minus the previous sample) are both nonzero and have the same sign. It falls by one step if both are nonzero and their signs are opposite. Both values are two's complement.
- R3: If `ph_err` is zero, or `mod_in` equals the previous sample, the estimate does not change on that edge.
- R4: The step size is 2 raised to the power `step_sel`, for `step_sel` from 0 to 15.
- R5: A rise that would go above `gain_max` gives `gain_max`. A fall that would go below `gain_min` gives `gain_min`. This holds even where a 16-bit add or subtract would wrap.
- R6: `mod_out` on the edge after a sample is that sample (signed) multiplied by the `gain_out` value (unsigned) current when the sample was presented. The latency is one cycle and the product is 29 bits wide.
- R7: With `cal_en`=0 and `pkt_start`=0, the estimate does not change.
- R8: On an edge where `cal_en` is 0 and it was 1 on the previous edge, the saved estimate takes the current estimate. On an edge with `pkt_start`=1, the estimate loads the saved value as it stood before that edge, whatever the signs and `cal_en` say.
- R9: The previous-sample register captures `mod_in` on every edge, whether or not calibration is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_en | input | 1 | Calibration active (loop locked and modulating) |
| pkt_start | input | 1 | Packet start pulse; reloads the saved estimate |
| mod_in | input | 12 | Signed modulation sample |
| ph_err | input | 10 | Signed filtered phase error |
| step_sel | input | 4 | Log2 of the adaptation step |
| gain_min | input | 16 | Lower bound of the estimate |
| gain_max | input | 16 | Upper bound of the estimate |
| gain_out | output | 16 | Current gain estimate |
| mod_out | output | 29 | Signed scaled modulation word for the oscillator |

## Verification
The bench checks the cases where a zero sign must freeze the estimate. A design that treated zero as positive would drift on flat modulation. It drives the estimate against both bounds with a step of 2^15, where a design that clamped after the add instead of before would wrap to a small value or jump to near full scale. It also checks a burst end and a packet start that land on the same edge, where a design with the wrong priority would reload the value it had just committed instead of the older saved value. Finally, it lets the modulation change while calibration is off and then checks the first enabled update. A design that froze the previous-sample register would take a wrong sign there.

// File: rtl/gcal_pkg.sv
package gcal_pkg;
  typedef enum logic [1:0] {DIR_HOLD = 2'd0, DIR_UP = 2'd1, DIR_DN = 2'd2} dir_t;

  // combine two three-state sign codes: 0 zero, 1 positive, 2 negative
  function automatic dir_t sign_product(input logic [1:0] a, input logic [1:0] b);
    if (a == 2'd0 || b == 2'd0) return DIR_HOLD;
    else if (a == b)            return DIR_UP;
    else                        return DIR_DN;
  endfunction
endpackage

// File: rtl/gcal_dir.sv
module gcal_dir
  import gcal_pkg::*;
#(
  parameter int MOD_W = 12,
  parameter int PE_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [MOD_W-1:0] mod_in,
  input  logic signed [PE_W-1:0]  ph_err,
  output dir_t                    dir
);
  logic signed [MOD_W-1:0] mod_q;
  logic [1:0] pe_sgn, dm_sgn;

  // previous sample tracks every edge (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_q <= '0;
    else        mod_q <= mod_in;
  end

  always_comb begin
    pe_sgn = (ph_err == '0) ? 2'd0 : (ph_err[PE_W-1] ? 2'd2 : 2'd1);
    if (mod_in > mod_q)      dm_sgn = 2'd1;
    else if (mod_in < mod_q) dm_sgn = 2'd2;
    else                     dm_sgn = 2'd0;
    dir = sign_product(pe_sgn, dm_sgn);
  end

  p_flat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_err == '0 || mod_in == mod_q) |-> (dir == DIR_HOLD));
endmodule

// File: rtl/gcal_acc.sv
module gcal_acc
  import gcal_pkg::*;
#(
  parameter int          GAIN_W    = 16,
  parameter int          SHIFT_W   = 4,
  parameter logic [15:0] INIT_GAIN = 16'h4000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cal_en,
  input  logic               pkt_start,
  input  dir_t               dir,
  input  logic [SHIFT_W-1:0] step_sel,
  input  logic [GAIN_W-1:0]  gain_min,
  input  logic [GAIN_W-1:0]  gain_max,
  output logic [GAIN_W-1:0]  gain_q
);
  localparam int XW = GAIN_W + 2;

  logic [GAIN_W-1:0] saved_q;
  logic              en_q;
  logic              reload, commit, upd;
  logic [GAIN_W-1:0] gain_nx;

  function automatic logic [GAIN_W-1:0] move_sat(
    input logic [GAIN_W-1:0] g, input logic up, input logic [SHIFT_W-1:0] sh,
    input logic [GAIN_W-1:0] lo, input logic [GAIN_W-1:0] hi);
    logic signed [XW-1:0] stp, res;
    stp = XW'(1) <<< sh;
    res = up ? ($signed({2'b00, g}) + stp) : ($signed({2'b00, g}) - stp);
    if (up && res > $signed({2'b00, hi}))       return hi;
    else if (!up && res < $signed({2'b00, lo})) return lo;
    else                                        return res[GAIN_W-1:0];
  endfunction

  assign reload  = pkt_start;
  assign commit  = en_q & ~cal_en;
  assign upd     = cal_en & ~reload & (dir != DIR_HOLD);
  assign gain_nx = move_sat(gain_q, dir == DIR_UP, step_sel, gain_min, gain_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= INIT_GAIN[GAIN_W-1:0];
      saved_q <= INIT_GAIN[GAIN_W-1:0];
      en_q    <= 1'b0;
    end else begin
      en_q <= cal_en;
      if (commit) saved_q <= gain_q;
      if (reload)   gain_q <= saved_q;
      else if (upd) gain_q <= gain_nx;
    end
  end

  p_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && gain_min <= gain_max) |=> (gain_q >= $past(gain_min) && gain_q <= $past(gain_max)));
  p_rise_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir == DIR_UP && gain_q <= gain_max) |=> (gain_q >= $past(gain_q)));
  p_fall_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir == DIR_DN && gain_q >= gain_min) |=> (gain_q <= $past(gain_q)));
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_en && !pkt_start) |=> $stable(gain_q));
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (gain_q == $past(saved_q)));
endmodule

// File: rtl/gcal_scale.sv
module gcal_scale #(
  parameter int MOD_W  = 12,
  parameter int GAIN_W = 16,
  localparam int OUT_W = MOD_W + GAIN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [MOD_W-1:0] mod_in,
  input  logic [GAIN_W-1:0]       gain,
  output logic signed [OUT_W-1:0] mod_out
);
  logic signed [OUT_W-1:0] prod;
  assign prod = mod_in * $signed({1'b0, gain});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mod_out <= '0;
    else        mod_out <= prod;
  end
endmodule

// File: rtl/osc_gain_tracker.sv
module osc_gain_tracker
  import gcal_pkg::*;
#(
  parameter int          MOD_W     = 12,
  parameter int          PE_W      = 10,
  parameter int          GAIN_W    = 16,
  parameter int          SHIFT_W   = 4,
  parameter logic [15:0] INIT_GAIN = 16'h4000,
  localparam int         OUT_W     = MOD_W + GAIN_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_en,
  input  logic                    pkt_start,
  input  logic signed [MOD_W-1:0] mod_in,
  input  logic signed [PE_W-1:0]  ph_err,
  input  logic [SHIFT_W-1:0]      step_sel,
  input  logic [GAIN_W-1:0]       gain_min,
  input  logic [GAIN_W-1:0]       gain_max,
  output logic [GAIN_W-1:0]       gain_out,
  output logic signed [OUT_W-1:0] mod_out
);
  dir_t dir;

  gcal_dir #(.MOD_W(MOD_W), .PE_W(PE_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .ph_err(ph_err), .dir(dir));

  gcal_acc #(.GAIN_W(GAIN_W), .SHIFT_W(SHIFT_W), .INIT_GAIN(INIT_GAIN)) u_acc (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .pkt_start(pkt_start), .dir(dir),
    .step_sel(step_sel), .gain_min(gain_min), .gain_max(gain_max), .gain_q(gain_out));

  gcal_scale #(.MOD_W(MOD_W), .GAIN_W(GAIN_W)) u_scale (
    .clk(clk), .rst_n(rst_n), .mod_in(mod_in), .gain(gain_out), .mod_out(mod_out));

  p_zero_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_in == '0) |=> (mod_out == '0));
  p_zero_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_out == '0) |=> (mod_out == '0));
endmodule

// File: tb/tb_osc_gain_tracker.sv
module tb_osc_gain_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_en = 1'b0, pkt_start = 1'b0;
  logic signed [11:0] mod_in = '0;
  logic signed [9:0]  ph_err = '0;
  logic [3:0]  step_sel = '0;
  logic [15:0] gain_min = 16'h3FF0, gain_max = 16'h4010;
  logic [15:0] gain_out;
  logic signed [28:0] mod_out;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;
  longint gexp = 16384;

  always #5 clk = ~clk;

  osc_gain_tracker dut (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .pkt_start(pkt_start), .mod_in(mod_in),
    .ph_err(ph_err), .step_sel(step_sel), .gain_min(gain_min), .gain_max(gain_max),
    .gain_out(gain_out), .mod_out(mod_out));

  // fields: en, pkt, mod[12], pe[10], step[4], expected gain[16]
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b0, 12'h00A, 10'h005, 4'd2, 16'h4004},  // R2 up
    {1'b1, 1'b0, 12'h014, 10'h3FD, 4'd2, 16'h4000},  // R2 down
    {1'b1, 1'b0, 12'h005, 10'h3F9, 4'd3, 16'h4008},  // R2 neg*neg, R4 step 8
    {1'b1, 1'b0, 12'h005, 10'h009, 4'd3, 16'h4008},  // R3 flat mod
    {1'b1, 1'b0, 12'hF9C, 10'h000, 4'd3, 16'h4008},  // R3 zero phase error
    {1'b1, 1'b0, 12'hFCE, 10'h001, 4'd4, 16'h4010},  // R5 ceiling
    {1'b0, 1'b0, 12'hFD8, 10'h001, 4'd4, 16'h4010},  // R7 idle, R8 commit
    {1'b0, 1'b0, 12'h01E, 10'h3FF, 4'd0, 16'h4010},  // R7 idle
    {1'b1, 1'b0, 12'h014, 10'h001, 4'd5, 16'h3FF0},  // R9 delta vs idle sample
    {1'b1, 1'b0, 12'h00A, 10'h001, 4'd1, 16'h3FF0},  // R5 floor
    {1'b1, 1'b1, 12'h028, 10'h001, 4'd1, 16'h4010},  // R8 reload beats update
    {1'b1, 1'b0, 12'h032, 10'h3FF, 4'd0, 16'h400F}   // R4 step 1
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; drives, waits for the update, samples at the next falling edge
  task automatic cyc(input logic e, input logic p, input logic signed [11:0] m,
                     input logic signed [9:0] pe, input logic [3:0] s,
                     input logic [15:0] eg, input string req);
    longint em;
    cal_en = e; pkt_start = p; mod_in = m; ph_err = pe; step_sel = s;
    em = longint'(m) * gexp;
    @(posedge clk);
    @(negedge clk);
    check({req, " gain"}, longint'(gain_out), longint'(eg));
    check("R6 mod_out", longint'(mod_out), em);
    gexp = longint'(eg);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gain", longint'(gain_out), 16384);
    check("R1 reset mod_out", longint'(mod_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      cyc(VEC[i][43], VEC[i][42], VEC[i][41:30], VEC[i][29:20], VEC[i][19:16],
          VEC[i][15:0], $sformatf("vec%0d R2/R3/R5/R7/R8", i));

    // wide bounds, largest step: wrap-safe saturation
    gain_min = 16'h0000; gain_max = 16'hFFFF;
    cyc(1'b1, 1'b0, 12'sd60,  10'sd1,  4'd15, 16'hC00F, "R4 step 2^15");
    cyc(1'b1, 1'b0, 12'sd70,  10'sd1,  4'd15, 16'hFFFF, "R5 overflow clamp");
    cyc(1'b1, 1'b0, 12'sd60,  10'sd1,  4'd15, 16'h7FFF, "R2 large fall");
    cyc(1'b1, 1'b0, 12'sd50,  10'sd1,  4'd15, 16'h0000, "R5 underflow clamp");
    cyc(1'b1, 1'b0, -12'sd2048, -10'sd1, 4'd0, 16'h0001, "R2 min sample");
    cyc(1'b1, 1'b0, 12'sd2047, 10'sd5,  4'd0, 16'h0002, "R6 max sample");
    // commit and reload on one edge: reload takes the older saved value
    cyc(1'b0, 1'b1, 12'sd0, 10'sd1, 4'd0, 16'h4010, "R8 commit+reload");
    cyc(1'b0, 1'b1, 12'sd0, 10'sd1, 4'd0, 16'h0002, "R8 reload committed");

    // reset mid-run
    cal_en = 1'b1; mod_in = 12'sd100; ph_err = 10'sd3;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset gain", longint'(gain_out), 16384);
    check("R1 mid reset mod_out", longint'(mod_out), 0);
    rst_n = 1'b1; gexp = 16384;
    gain_min = 16'h3FF0; gain_max = 16'h4010;
    // previous sample was cleared to 0 by reset (R9): 5 > 0 with positive error rises
    cyc(1'b1, 1'b0, 12'sd5, 10'sd3, 4'd0, 16'h4001, "R9 prev cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule